// File: doc/BRIEF.md
# Three-wire serial EEPROM host controller

This block is the master side of a three-wire serial EEPROM link for a part organised as 8-bit words. A command port with a valid/ready handshake takes an operation, an address, write data and a read burst length. The controller then raises chip select and drives the serial clock. It shifts the command frame out MSB first on the data-out line and collects data from the device's output line.

A read drops the single zero bit that the device sends ahead of its data. It then returns one or more 8-bit words, each marked by a one-cycle strobe. Successive words come from ascending addresses while select stays high. A programming command (write, erase, erase-all, write-all) ends with a low pulse on select. Select then rises again and the device's output is polled until it reports ready. If it does not report ready in time, an error pulse is raised. Every timing interval is a parameter counted in system clocks.

Top module: `uwire_host`

## Requirements
- R1: After reset, select, serial clock and serial data out are low, `cmd_ready_o` is high and `rd_valid_o` and `err_o` are low.
- R2: `cmd_op_i` encodes 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 enable, 6 disable, and 7 behaves as disable. The frame, sent MSB first, is a 1 start bit and then a 2-bit code: read 10, write 01, erase 11, all others 00. Read, write and erase follow the code with a 0 bit and 8 address bits. The other operations follow it with two extension bits (enable 11, erase-all 10, write-all 01, disable 00) and seven 0 bits. Write and write-all then append 8 data bits. This gives 12 or 20 rising clock edges.
- R3: The serial clock toggles only while select is high. Each rising edge follows at least `SCK_LO` low cycles, and each high phase lasts at least `SCK_HI` cycles.
- R4: Serial data out changes only while the serial clock is low.
- R5: Between any two high periods of select, it stays low for at least `CS_GAP` cycles.
- R6: A read ignores the first sampled bit after the address. It then returns `cmd_len_i`+1 words, each built MSB first from 8 samples and flagged by a one-cycle `rd_valid_o`. The words come from consecutive addresses that wrap modulo 256, all within one select period.
- R7: After a programming command, select drops for `CS_GAP` cycles, then rises. After at least `STAT_DLY` cycles, the device output is sampled every cycle until it reads 1, and then select drops.
- R8: If `POLL_MAX` consecutive status samples read 0, `err_o` pulses for one cycle, select drops and the controller goes back to idle.
- R9: `cmd_ready_o` is low from acceptance until select has been released and `CS_GAP` cycles have passed, and it is never high while select is high.
- R10: Read, enable and disable raise select exactly once per command; they do not poll status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Controller idle, command accepted when valid |
| cmd_op_i | input | 3 | Operation code |
| cmd_addr_i | input | AW | Word address |
| cmd_wdata_i | input | DW | Write data |
| cmd_len_i | input | LW | Read burst length minus one |
| rd_valid_o | output | 1 | Read word strobe |
| rd_data_o | output | DW | Read word |
| err_o | output | 1 | Status poll timeout pulse |
| cs_o | output | 1 | Chip select to device |
| sck_o | output | 1 | Serial clock to device |
| di_o | output | 1 | Serial data to device |
| do_i | input | 1 | Serial data and status from device |

## Verification
The assertions assume a monotonic system clock and a device that drives its output only as a function of the controller's own select and clock lines. They do not assume any timing of `do_i`, because the controller samples that line at fixed points. The timing properties are measured with cycle counters in the checker and compared against the parameters. The stimulus comes from a behavioural device model that reacts half a clock after each controller edge. That model holds its busy time for a programmable count, which is set longer than `POLL_MAX` only in the timeout test.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_ERAL  = 3'd3,
    OP_WRAL  = 3'd4,
    OP_EWEN  = 3'd5,
    OP_EWDS  = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SHIFT, S_GAP, S_SETTLE, S_POLL
  } st_e;
endpackage

// File: rtl/uwire_frame.sv
module uwire_frame
  import uwire_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int FW  = 4 + AW + DW,
  localparam int FLW = $clog2(FW + 1)
) (
  input  logic [2:0]     op_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [FW-1:0]  bits_o,
  output logic [FLW-1:0] len_o,
  output logic           rd_o,
  output logic           prog_o
);
  logic [1:0]  opc;
  logic [AW:0] body;
  logic        data_on;

  always_comb begin
    opc     = 2'b00;
    body    = '0;
    data_on = 1'b0;
    rd_o    = 1'b0;
    prog_o  = 1'b0;
    case (op_e'(op_i))
      OP_READ:  begin opc = 2'b10; body = {1'b0, addr_i}; rd_o = 1'b1; end
      OP_WRITE: begin opc = 2'b01; body = {1'b0, addr_i}; data_on = 1'b1; prog_o = 1'b1; end
      OP_ERASE: begin opc = 2'b11; body = {1'b0, addr_i}; prog_o = 1'b1; end
      OP_ERAL:  begin body = {2'b10, {(AW-1){1'b0}}}; prog_o = 1'b1; end
      OP_WRAL:  begin body = {2'b01, {(AW-1){1'b0}}}; data_on = 1'b1; prog_o = 1'b1; end
      OP_EWEN:  body = {2'b11, {(AW-1){1'b0}}};
      default:  body = '0;
    endcase
    // left-justified; trailing data slot zero when unused
    bits_o = {1'b1, opc, body, data_on ? wdata_i : {DW{1'b0}}};
    len_o  = data_on ? FLW'(FW) : FLW'(FW - DW);
  end
endmodule

// File: rtl/uwire_rx.sv
module uwire_rx #(
  parameter int DW = 8,
  localparam int CW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          bit_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  logic [DW-1:0] sr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr      <= '0;
      cnt     <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        cnt <= '0;
      end else if (en_i) begin
        sr <= {sr[DW-2:0], bit_i};
        if (cnt == CW'(DW - 1)) begin
          cnt     <= '0;
          data_o  <= {sr[DW-2:0], bit_i};
          valid_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uwire_host.sv
module uwire_host
  import uwire_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int LW       = 4,
  parameter int SCK_LO   = 3,
  parameter int SCK_HI   = 3,
  parameter int CS_GAP   = 4,
  parameter int STAT_DLY = 3,
  parameter int POLL_MAX = 200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [2:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  input  logic [LW-1:0] cmd_len_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          err_o,
  output logic          cs_o,
  output logic          sck_o,
  output logic          di_o,
  input  logic          do_i
);
  localparam int FW   = 4 + AW + DW;
  localparam int FLW  = $clog2(FW + 1);
  localparam int SW   = $clog2(FW + 2 + DW * (2 ** LW));
  localparam int TM1  = (SCK_LO > SCK_HI) ? SCK_LO : SCK_HI;
  localparam int TM2  = (CS_GAP > STAT_DLY) ? CS_GAP : STAT_DLY;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(POLL_MAX + 1);
  localparam logic [TW-1:0] T_LO  = TW'(SCK_LO - 1);
  localparam logic [TW-1:0] T_HI  = TW'(SCK_HI - 1);
  localparam logic [TW-1:0] T_GAP = TW'(CS_GAP - 1);
  localparam logic [TW-1:0] T_ST  = TW'(STAT_DLY - 1);

  logic [FW-1:0]  f_bits;
  logic [FLW-1:0] f_len;
  logic           f_rd, f_prog;

  uwire_frame #(.AW(AW), .DW(DW)) u_frame (
    .op_i(cmd_op_i), .addr_i(cmd_addr_i), .wdata_i(cmd_wdata_i),
    .bits_o(f_bits), .len_o(f_len), .rd_o(f_rd), .prog_o(f_prog)
  );

  st_e           state;
  logic [FW-1:0] frame_sr;
  logic [TW-1:0] tmr;
  logic [SW-1:0] slot, nslots, flen_q;
  logic [PW-1:0] pcnt;
  logic          hi_ph, is_rd_q, poll_q;
  logic          cs_q, sck_q, di_q, err_q;
  logic          accept, smp_en;

  assign accept = (state == S_IDLE) && cmd_valid_i;
  // sample just before the rising edge; slot flen_q holds the dummy bit
  assign smp_en = (state == S_SHIFT) && (tmr == '0) && !hi_ph && is_rd_q && (slot > flen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= S_IDLE;
      frame_sr <= '0;
      tmr      <= '0;
      slot     <= '0;
      nslots   <= '0;
      flen_q   <= '0;
      pcnt     <= '0;
      hi_ph    <= 1'b0;
      is_rd_q  <= 1'b0;
      poll_q   <= 1'b0;
      cs_q     <= 1'b0;
      sck_q    <= 1'b0;
      di_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid_i) begin
          frame_sr <= f_bits;
          di_q     <= f_bits[FW-1];
          cs_q     <= 1'b1;
          hi_ph    <= 1'b0;
          slot     <= '0;
          flen_q   <= SW'(f_len);
          nslots   <= SW'(f_len) + (f_rd ? (SW'(1) + SW'(DW) * (SW'(cmd_len_i) + SW'(1))) : SW'(0));
          is_rd_q  <= f_rd;
          poll_q   <= f_prog;
          tmr      <= T_LO;
          state    <= S_SHIFT;
        end
        S_SHIFT: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else if (!hi_ph) begin
            sck_q <= 1'b1;
            hi_ph <= 1'b1;
            tmr   <= T_HI;
          end else begin
            sck_q <= 1'b0;
            hi_ph <= 1'b0;
            if (slot == nslots - 1'b1) begin
              cs_q  <= 1'b0;
              di_q  <= 1'b0;
              tmr   <= T_GAP;
              state <= S_GAP;
            end else begin
              slot     <= slot + 1'b1;
              frame_sr <= {frame_sr[FW-2:0], 1'b0};
              di_q     <= frame_sr[FW-2];
              tmr      <= T_LO;
            end
          end
        end
        S_GAP: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else if (poll_q) begin
            poll_q <= 1'b0;
            cs_q   <= 1'b1;
            tmr    <= T_ST;
            state  <= S_SETTLE;
          end else begin
            state <= S_IDLE;
          end
        end
        S_SETTLE: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            pcnt  <= '0;
            state <= S_POLL;
          end
        end
        S_POLL: begin
          if (do_i || pcnt == PW'(POLL_MAX - 1)) begin
            cs_q  <= 1'b0;
            err_q <= !do_i;
            tmr   <= T_GAP;
            state <= S_GAP;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  uwire_rx #(.DW(DW)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .en_i(smp_en), .bit_i(do_i),
    .data_o(rd_data_o), .valid_o(rd_valid_o)
  );

  assign cmd_ready_o = (state == S_IDLE);
  assign cs_o        = cs_q;
  assign sck_o       = sck_q;
  assign di_o        = di_q;
  assign err_o       = err_q;
endmodule

// File: rtl/uwire_host_chk.sv
module uwire_host_chk #(
  parameter int SCK_LO = 3,
  parameter int SCK_HI = 3,
  parameter int CS_GAP = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_ready_o,
  input logic rd_valid_o,
  input logic err_o,
  input logic cs_o,
  input logic sck_o,
  input logic di_o
);
  int lo_cnt, hi_cnt, gap_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt  <= 0;
      hi_cnt  <= 0;
      gap_cnt <= CS_GAP;
    end else begin
      if (!cs_o || sck_o) lo_cnt <= 0;
      else if (lo_cnt < SCK_LO) lo_cnt <= lo_cnt + 1;
      if (!sck_o) hi_cnt <= 0;
      else if (hi_cnt < SCK_HI) hi_cnt <= hi_cnt + 1;
      if (cs_o) gap_cnt <= 0;
      else if (gap_cnt < CS_GAP) gap_cnt <= gap_cnt + 1;
    end
  end

  // R3
  sck_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !cs_o |-> !sck_o);
  // R3
  sck_low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(sck_o) |-> lo_cnt >= SCK_LO);
  // R3
  sck_high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(sck_o) |-> hi_cnt >= SCK_HI);
  // R4
  di_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) sck_o |-> $stable(di_o));
  // R5
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(cs_o) |-> gap_cnt >= CS_GAP);
  // R9
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cs_o |-> !cmd_ready_o);
  // R6
  rd_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_valid_o |-> cs_o);
  // R8
  err_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |-> !cs_o && $past(cs_o));
endmodule

bind uwire_host uwire_host_chk #(.SCK_LO(SCK_LO), .SCK_HI(SCK_HI), .CS_GAP(CS_GAP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_ready_o(cmd_ready_o), .rd_valid_o(rd_valid_o),
  .err_o(err_o), .cs_o(cs_o), .sck_o(sck_o), .di_o(di_o)
);

// File: tb/tb_uwire_host.sv
module tb_uwire_host;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic       cmd_ready_o;
  logic [2:0] cmd_op_i = '0;
  logic [7:0] cmd_addr_i = '0;
  logic [7:0] cmd_wdata_i = '0;
  logic [3:0] cmd_len_i = '0;
  logic       rd_valid_o;
  logic [7:0] rd_data_o;
  logic       err_o, cs_o, sck_o, di_o;
  logic       do_i = 1'b0;

  always #2 clk_i = ~clk_i;

  uwire_host dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural device model
  logic [7:0]  dmem [256];
  logic [7:0]  exp_mem [256];
  logic [19:0] cap, fr_cap;
  logic [7:0]  sh, raddr;
  int n = 0, fr_n = 0, bc = 0, busy = 0, busy_len = 30, busy_end = 0;
  int cs_rises = 0, err_cnt = 0;
  bit en = 0, rd_mode = 0, dout = 0, cs_p = 0, sck_p = 0;
  logic [7:0] rdq[$];

  task automatic exec_frame();
    logic [1:0] op, ext;
    logic [7:0] a, d;
    op = (n == 20) ? cap[18:17] : cap[10:9];
    ext = (n == 20) ? cap[16:15] : cap[8:7];
    a = (n == 20) ? cap[15:8] : cap[7:0];
    d = cap[7:0];
    if (op == 2'b00 && ext == 2'b11) en = 1;
    else if (op == 2'b00 && ext == 2'b00) en = 0;
    else if (en) begin
      if (op == 2'b01 && n == 20) dmem[a] = d;
      else if (op == 2'b11) dmem[a] = 8'hFF;
      else if (op == 2'b00 && ext == 2'b10) for (int i = 0; i < 256; i++) dmem[i] = 8'hFF;
      else if (op == 2'b00 && ext == 2'b01 && n == 20) for (int i = 0; i < 256; i++) dmem[i] = d;
      if (op != 2'b10) busy = busy_len;
    end
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      chk(!(sck_o && !cs_o), "R3", "clock without select", sck_o, 0);
      chk(!(cs_o && cmd_ready_o), "R9", "ready while selected", cmd_ready_o, 0);
    end
    if (cs_o && !cs_p) begin n = 0; cap = '0; rd_mode = 0; cs_rises++; end
    if (!cs_o && cs_p) begin
      if (n > 0) begin fr_n = n; fr_cap = cap; end
      if (!rd_mode && (n == 12 || n == 20)) exec_frame();
      rd_mode = 0;
    end
    if (cs_o && sck_o && !sck_p) begin
      n++;
      if (n <= 20) cap = {cap[18:0], di_o};
      if (rd_mode) begin
        dout = sh[7];
        sh = {sh[6:0], 1'b0};
        bc++;
        if (bc == 8) begin bc = 0; raddr = raddr + 8'd1; sh = dmem[raddr]; end
      end else if (n == 12 && cap[10:9] == 2'b10) begin
        rd_mode = 1; raddr = cap[7:0]; sh = dmem[raddr]; bc = 0; dout = 0;
      end
    end
    if (busy > 0) begin busy--; if (busy == 0) busy_end = cyc; end
    if (rd_valid_o) rdq.push_back(rd_data_o);
    if (err_o) err_cnt++;
    do_i = cs_o ? (rd_mode ? dout : (busy == 0)) : 1'b0;
    cs_p = cs_o;
    sck_p = sck_o;
  end

  function automatic logic [19:0] exp_frame(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d, output int len);
    len = 12;
    case (op)
      3'd0: return {8'h0, 1'b1, 2'b10, 1'b0, a};
      3'd1: begin len = 20; return {1'b1, 2'b01, 1'b0, a, d}; end
      3'd2: return {8'h0, 1'b1, 2'b11, 1'b0, a};
      3'd3: return {8'h0, 1'b1, 2'b00, 2'b10, 7'h0};
      3'd4: begin len = 20; return {1'b1, 2'b00, 2'b01, 7'h0, d}; end
      3'd5: return {8'h0, 1'b1, 2'b00, 2'b11, 7'h0};
      default: return {8'h0, 1'b1, 2'b00, 2'b00, 7'h0};
    endcase
  endfunction

  int rises0, err0, ready_cyc;

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d, input logic [3:0] len);
    int elen;
    logic [19:0] ef;
    do @(negedge clk_i); while (!cmd_ready_o);
    rises0 = cs_rises;
    err0 = err_cnt;
    rdq.delete();
    cmd_op_i = op; cmd_addr_i = a; cmd_wdata_i = d; cmd_len_i = len;
    cmd_valid_i = 1'b1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    do @(negedge clk_i); while (!cmd_ready_o);
    ready_cyc = cyc;
    ef = exp_frame(op, a, d, elen);
    if (op == 3'd0) begin
      chk(fr_cap[19:8] == ef[11:0], "R2", "read frame", int'(fr_cap[19:8]), int'(ef[11:0]));
    end else begin
      chk(fr_n == elen, "R2", "edge count", fr_n, elen);
      chk(fr_cap == ef, "R2", "frame bits", int'(fr_cap), int'(ef));
    end
  endtask

  task automatic prog(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
    run_cmd(op, a, d, 4'd0);
    chk(cs_rises - rises0 == 2, "R7", "select periods", cs_rises - rises0, 2);
    chk(ready_cyc > busy_end, "R7", "ready after busy", ready_cyc, busy_end);
    chk(err_cnt == err0, "R8", "spurious error", err_cnt - err0, 0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] len);
    run_cmd(3'd0, a, 8'h0, len);
    chk(cs_rises - rises0 == 1, "R10", "read select periods", cs_rises - rises0, 1);
    chk(rdq.size() == int'(len) + 1, "R6", "word count", rdq.size(), int'(len) + 1);
    for (int i = 0; i < rdq.size(); i++) begin
      logic [7:0] ea;
      ea = a + 8'(i);
      chk(rdq[i] == exp_mem[ea], "R6", "read word", int'(rdq[i]), int'(exp_mem[ea]));
    end
  endtask

  task automatic ctl(input logic [2:0] op);
    run_cmd(op, 8'h0, 8'h0, 4'd0);
    chk(cs_rises - rises0 == 1, "R10", "control select periods", cs_rises - rises0, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin dmem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!cs_o && !sck_o && !di_o, "R1", "idle lines", {cs_o, sck_o, di_o}, 0);
    chk(cmd_ready_o && !rd_valid_o && !err_o, "R1", "idle flags", {cmd_ready_o, rd_valid_o, err_o}, 3'b100);

    ctl(3'd5);
    prog(3'd1, 8'h3C, 8'h5A); exp_mem[8'h3C] = 8'h5A;
    rd(8'h3C, 4'd0);
    prog(3'd1, 8'h3D, 8'hC3); exp_mem[8'h3D] = 8'hC3;
    rd(8'h3C, 4'd1);
    prog(3'd2, 8'h3C, 8'h00); exp_mem[8'h3C] = 8'hFF;
    rd(8'h3B, 4'd2);
    prog(3'd4, 8'h00, 8'h11); for (int i = 0; i < 256; i++) exp_mem[i] = 8'h11;
    rd(8'hFE, 4'd2);
    prog(3'd3, 8'h00, 8'h00); for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
    rd(8'h00, 4'd0);
    ctl(3'd6);
    ctl(3'd7);

    // R8: device busy longer than the poll window
    ctl(3'd5);
    busy_len = 1000;
    run_cmd(3'd1, 8'h10, 8'h77, 4'd0); exp_mem[8'h10] = 8'h77;
    chk(err_cnt - err0 == 1, "R8", "timeout pulse", err_cnt - err0, 1);
    chk(cs_rises - rises0 == 2, "R8", "select periods", cs_rises - rises0, 2);
    chk(!cs_o && cmd_ready_o, "R8", "back to idle", {cs_o, cmd_ready_o}, 1);
    repeat (1100) @(negedge clk_i);
    busy_len = 30;
    rd(8'h10, 4'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=idle");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule